// File: doc/BRIEF.md
# Row-Column Microprogram Address Sequencer

This block produces the address of the next microword for a 512-word control store. It treats the store as a grid of 32 rows by 16 columns, with the row in address bits [8:4] and the column in bits [3:0]. A branch never loads an arbitrary address. Each jump keeps part of the current position and takes the rest from fields in the current microword. The supported jumps are:

- to row 0;
- to another column in the same row;
- to another row in the same column;
- to a cell inside the current group of four rows.

Conditional forms of these jumps put a condition flag in place of the lowest column or row bit. The result is a two-way branch between neighbouring cells.

The microword supplies three things each cycle: a 3-bit jump code, a row field and a column field. The address register takes its new value on every rising clock edge.

The block also handles carry for a chain of ALU slices. It drives the carry-in of the chain from a 2-bit selector. It can store the carry-out of the chain in a flag, which a later microword can feed back as carry-in.

Top module: `useq_rowcol`

## Requirements
- R1: While rst_n is low, the next rising edge sets addr to 0 (row 0, column 0) and clears co_flag.
- R2: Jump code 0 loads row 0 and column col_f.
- R3: Jump code 1 keeps the current row and loads column col_f.
- R4: Jump code 2 keeps the current column and loads row row_f.
- R5: Jump code 3 keeps row bits [4:2], takes row bits [1:0] from row_f[1:0], and loads column col_f.
- R6: Jump code 4 keeps the current row and loads column {col_f[3:1], cond}.
- R7: Jump code 5 keeps the current column and loads row {row_f[4:1], cond}.
- R8: Jump code 6 loads row 0 and column {col_f[3:1], cond}. Jump code 7 forms the row as in R5 and loads column {col_f[3:1], cond}.
- R9: ci_out is combinational and follows ci_sel: 0 gives 0, 1 gives 1, 2 gives co_flag, 3 gives cond.
- R10: On a rising edge with co_cap high, co_flag takes the value of co_in. With co_cap low, co_flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| jfn | input | 3 | Jump code from the microword |
| row_f | input | 5 | Row field from the microword |
| col_f | input | 4 | Column field from the microword |
| cond | input | 1 | Condition flag for conditional jumps |
| ci_sel | input | 2 | Carry-in source select |
| co_in | input | 1 | Carry-out of the ALU slice chain |
| co_cap | input | 1 | Capture enable for co_in |
| addr | output | 9 | Registered microprogram address, {row, column} |
| ci_out | output | 1 | Carry-in to the ALU slice chain |
| co_flag | output | 1 | Stored carry |

## Verification
The cases hardest to reach are the subset jumps. They keep the upper row bits of the current address, so they only mean something after an earlier jump has moved the address into a row group other than 0. The stimulus therefore walks the address through all eight jump codes in long random sequences, and directed steps first place it in a high row group before issuing codes 3 and 7. The stored-carry path to ci_out is exercised by capturing a carry and then selecting code 2 for several cycles with co_cap low.

// File: rtl/useq_rowcol.sv
module useq_rowcol #(
  parameter int ROW_W = 5,
  parameter int COL_W = 4,
  parameter int SUB_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             jfn,
  input  logic [ROW_W-1:0]       row_f,
  input  logic [COL_W-1:0]       col_f,
  input  logic                   cond,
  input  logic [1:0]             ci_sel,
  input  logic                   co_in,
  input  logic                   co_cap,
  output logic [ROW_W+COL_W-1:0] addr,
  output logic                   ci_out,
  output logic                   co_flag
);
  localparam int AW = ROW_W + COL_W;

  logic [ROW_W-1:0] cur_row, row_c, row_s, nxt_row;
  logic [COL_W-1:0] cur_col, col_c, nxt_col;

  assign cur_row = addr[AW-1:COL_W];
  assign cur_col = addr[COL_W-1:0];
  assign col_c   = {col_f[COL_W-1:1], cond};
  assign row_c   = {row_f[ROW_W-1:1], cond};
  assign row_s   = {cur_row[ROW_W-1:SUB_W], row_f[SUB_W-1:0]};

  always_comb begin
    nxt_row = cur_row;
    nxt_col = cur_col;
    case (jfn)
      3'd0: begin nxt_row = '0;    nxt_col = col_f; end
      3'd1: begin                  nxt_col = col_f; end
      3'd2: begin nxt_row = row_f;                  end
      3'd3: begin nxt_row = row_s; nxt_col = col_f; end
      3'd4: begin                  nxt_col = col_c; end
      3'd5: begin nxt_row = row_c;                  end
      3'd6: begin nxt_row = '0;    nxt_col = col_c; end
      default: begin nxt_row = row_s; nxt_col = col_c; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr    <= '0;
      co_flag <= 1'b0;
    end else begin
      addr <= {nxt_row, nxt_col};
      if (co_cap) co_flag <= co_in;
    end
  end

  always_comb begin
    case (ci_sel)
      2'd0:    ci_out = 1'b0;
      2'd1:    ci_out = 1'b1;
      2'd2:    ci_out = co_flag;
      default: ci_out = cond;
    endcase
  end
endmodule

// File: rtl/useq_rowcol_chk.sv
module useq_rowcol_chk #(
  parameter int ROW_W = 5,
  parameter int COL_W = 4,
  parameter int SUB_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [2:0]             jfn,
  input logic [ROW_W-1:0]       row_f,
  input logic [COL_W-1:0]       col_f,
  input logic                   cond,
  input logic [1:0]             ci_sel,
  input logic                   co_in,
  input logic                   co_cap,
  input logic [ROW_W+COL_W-1:0] addr,
  input logic                   ci_out,
  input logic                   co_flag
);
  localparam int AW = ROW_W + COL_W;

  // R1
  reset_state_chk: assert property (@(posedge clk) !rst_n |=> (addr == '0 && !co_flag));
  // R2
  row_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jfn == 3'd0 |=> (addr[AW-1:COL_W] == '0 && addr[COL_W-1:0] == $past(col_f)));
  // R3
  same_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jfn == 3'd1 |=> addr[AW-1:COL_W] == $past(addr[AW-1:COL_W]));
  // R4
  same_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jfn == 3'd2 |=> (addr[COL_W-1:0] == $past(addr[COL_W-1:0]) && addr[AW-1:COL_W] == $past(row_f)));
  // R5
  subset_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jfn == 3'd3 |=> addr[AW-1:COL_W+SUB_W] == $past(addr[AW-1:COL_W+SUB_W]));
  // R6
  cond_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jfn == 3'd4 |=> addr[0] == $past(cond));
  // R7
  cond_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jfn == 3'd5 |=> (addr[COL_W] == $past(cond) && addr[COL_W-1:0] == $past(addr[COL_W-1:0])));
  // R8
  cond_row0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jfn == 3'd6 |=> (addr[AW-1:COL_W] == '0 && addr[0] == $past(cond)));
  // R9
  stored_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ci_sel == 2'd2 |-> ci_out == co_flag);
  // R10
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !co_cap |=> $stable(co_flag));
  // R10
  carry_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    co_cap |=> co_flag == $past(co_in));
endmodule

bind useq_rowcol useq_rowcol_chk #(.ROW_W(ROW_W), .COL_W(COL_W), .SUB_W(SUB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .jfn(jfn), .row_f(row_f), .col_f(col_f), .cond(cond),
  .ci_sel(ci_sel), .co_in(co_in), .co_cap(co_cap), .addr(addr), .ci_out(ci_out),
  .co_flag(co_flag));

// File: tb/useq_rowcol_bench.sv
`timescale 1ns/1ps
module useq_rowcol_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] jfn = '0;
  logic [4:0] row_f = '0;
  logic [3:0] col_f = '0;
  logic cond = 1'b0;
  logic [1:0] ci_sel = '0;
  logic co_in = 1'b0;
  logic co_cap = 1'b0;
  logic [8:0] addr;
  logic ci_out, co_flag;

  int checks = 0;
  int errors = 0;
  int m_addr = 0;
  int m_flag = 0;

  always #2 clk = ~clk;

  useq_rowcol u_useq_rowcol (
    .clk(clk), .rst_n(rst_n), .jfn(jfn), .row_f(row_f), .col_f(col_f), .cond(cond),
    .ci_sel(ci_sel), .co_in(co_in), .co_cap(co_cap), .addr(addr), .ci_out(ci_out),
    .co_flag(co_flag));

  function automatic string req_of(int code);
    case (code)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_next(int a, int code, int rf, int cf, int c);
    int r = a >> 4;
    int k = a & 15;
    int cc = (cf & 14) | c;
    case (code)
      0: begin r = 0; k = cf; end
      1: k = cf;
      2: r = rf;
      3: begin r = (r & 28) | (rf & 3); k = cf; end
      4: k = cc;
      5: r = (rf & 30) | c;
      6: begin r = 0; k = cc; end
      default: begin r = (r & 28) | (rf & 3); k = cc; end
    endcase
    return (r << 4) | k;
  endfunction

  function automatic int ref_ci(int sel, int c);
    case (sel)
      0: return 0;
      1: return 1;
      2: return m_flag;
      default: return c;
    endcase
  endfunction

  task automatic step(int code, int rf, int cf, int c, int sel, int ci, int cap);
    jfn = code[2:0]; row_f = rf[4:0]; col_f = cf[3:0]; cond = c[0];
    ci_sel = sel[1:0]; co_in = ci[0]; co_cap = cap[0];
    #1;
    check("R9", int'(ci_out), ref_ci(sel, c));
    @(posedge clk);
    m_addr = ref_next(m_addr, code, rf, cf, c);
    if (cap != 0) m_flag = ci;
    #1;
    check(req_of(code), int'(addr), m_addr);
    check("R10", int'(co_flag), m_flag);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(addr), 0);
    check("R1", int'(co_flag), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(2, 29, 0, 0, 0, 1, 1);
    step(1, 0, 9, 0, 2, 0, 0);
    step(3, 2, 5, 0, 2, 0, 0);
    step(7, 1, 6, 1, 3, 0, 0);
    step(4, 0, 12, 1, 1, 0, 1);
    step(5, 17, 0, 1, 2, 1, 0);
    step(5, 17, 0, 0, 2, 1, 0);
    step(6, 0, 11, 0, 0, 1, 1);
    step(0, 31, 15, 1, 2, 0, 0);
    for (int i = 0; i < 2000; i++)
      step($urandom_range(0, 7), $urandom_range(0, 31), $urandom_range(0, 15),
           $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 1),
           $urandom_range(0, 1));
    step(2, 20, 0, 0, 0, 1, 1);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check("R1", int'(addr), 0);
    check("R1", int'(co_flag), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule